// File: doc/BRIEF.md
# Paged Address Translator with Associative Entry Cache

This block turns a 32-bit logical address into a physical address for a paged memory with 4 KB pages. The low 12 bits, the byte position inside the page, go through unchanged. The upper 20 bits, the page number, are compared against every entry of a small fully associative cache of recently used page-table entries.

When the page number matches a cached entry, the cached frame number becomes the upper part of the physical address. No memory access is made in that case. When nothing matches, the block makes one read of the page table in memory. The entry address is the page-table base register plus four times the page number. The block then installs the returned entry in the cache and answers.

A flush input empties the cache, for use at a context switch. Requests arrive through a valid/ready handshake, and only one translation is handled at a time.

Top module: `addr_xlate`

## Requirements
- R1: For every successful translation, bits 11:0 of `rsp_paddr` equal bits 11:0 of the accepted `req_vaddr`.
- R2: On a cache hit, `rsp_valid` is high for one cycle, on the second rising edge after the request is accepted. In that case `rsp_hit`=1, `rsp_fault`=0, and `rsp_paddr[31:12]` is the cached frame number. No memory read takes place during the translation.
- R3: On a miss, `mem_rd_en` rises, with `mem_rd_addr` = `pt_base` + 4 × page number (32-bit wrap-around). It stays high until a cycle in which `mem_rd_valid` is high.
- R4: A fetched entry is usable when bit 31 is 1 and bits 30:20 are 0. Its frame number is in bits 19:0. For a usable entry, the response comes on the edge that samples `mem_rd_valid`, with `rsp_paddr` = {frame, offset}, `rsp_hit`=0 and `rsp_fault`=0. The entry is installed, so the next access to that page is a hit.
- R5: For an entry with bit 31 clear, or with any of bits 30:20 set, the response has `rsp_fault`=1, `rsp_hit`=0 and `rsp_paddr`=0. Nothing is installed, so the next access to that page misses again.
- R6: The cache holds 8 entries. Fills replace slots in round-robin order: the pointer starts at slot 0 after reset, advances only on a fill, and a flush leaves it where it is. After 9 fills in a row, the page installed first is gone and the other 8 still hit.
- R7: A cycle with `flush` high invalidates every entry. A fill that lands in the same cycle is discarded, although the response in that cycle is still given.
- R8: `req_ready` is high only while no translation is in progress. It falls after acceptance and rises again in the cycle in which the response is presented.
- R9: After reset, `req_ready`=1, `rsp_valid`=0, `mem_rd_en`=0, and the cache is empty, so the first access misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can take a request |
| req_vaddr | input | 32 | Logical address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_hit | output | 1 | Response came from the cache |
| rsp_fault | output | 1 | Fetched entry unusable |
| mem_rd_en | output | 1 | Page-table read request, held until data |
| mem_rd_addr | output | 32 | Byte address of the page-table entry |
| mem_rd_valid | input | 1 | Read data present this cycle |
| mem_rd_data | input | 32 | Page-table entry |
| pt_base | input | 32 | Page-table base address |
| flush | input | 1 | Invalidate all cached entries |

## Verification
The hardest case to reach is a flush that arrives in exactly the cycle a fill is being written. The bench reaches it by driving `flush` at the same falling edge at which its memory model returns the entry. It then shows that the fill was dropped by requesting the same page again and observing a second table read. Round-robin eviction is reached by flushing first and then making nine distinct valid misses. The bench then reads back which pages still hit and which one misses, and checks the result against a behavioural cache model. The memory latency is varied per page, so that the hold of the read request across wait cycles is exercised.

// File: rtl/addr_xlate.sv
module addr_xlate #(
  parameter int VA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int PTE_W   = 32,
  parameter int ENTRIES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             rsp_valid,
  output logic [VA_W-1:0]  rsp_paddr,
  output logic             rsp_hit,
  output logic             rsp_fault,
  output logic             mem_rd_en,
  output logic [VA_W-1:0]  mem_rd_addr,
  input  logic             mem_rd_valid,
  input  logic [PTE_W-1:0] mem_rd_data,
  input  logic [VA_W-1:0]  pt_base,
  input  logic             flush
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int IDX_W = $clog2(ENTRIES);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_FETCH} st_t;
  st_t st;

  logic [VA_W-1:0]    va_q;
  logic [ENTRIES-1:0] ent_v;
  logic [VPN_W-1:0]   ent_tag [ENTRIES];
  logic [VPN_W-1:0]   ent_frm [ENTRIES];
  logic [IDX_W-1:0]   rr;
  logic               hit;
  logic [VPN_W-1:0]   hit_frm;

  wire [VPN_W-1:0] vpn    = va_q[VA_W-1:OFF_W];
  wire             pte_ok = mem_rd_data[PTE_W-1] && (mem_rd_data[PTE_W-2:VPN_W] == '0);
  wire             fill   = mem_rd_en && mem_rd_valid && pte_ok && !flush;

  assign req_ready   = (st == S_IDLE);
  assign mem_rd_en   = (st == S_FETCH);
  assign mem_rd_addr = pt_base + {{(OFF_W-2){1'b0}}, vpn, 2'b00};

  always_comb begin
    hit     = 1'b0;
    hit_frm = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (ent_v[i] && ent_tag[i] == vpn) begin
        hit     = 1'b1;
        hit_frm = hit_frm | ent_frm[i];
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      va_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          va_q <= req_vaddr;
          st   <= S_LOOK;
        end
        S_LOOK: if (hit) begin
          rsp_valid <= 1'b1;
          rsp_hit   <= 1'b1;
          rsp_paddr <= {hit_frm, va_q[OFF_W-1:0]};
          st        <= S_IDLE;
        end else begin
          st <= S_FETCH;
        end
        S_FETCH: if (mem_rd_valid) begin
          rsp_valid <= 1'b1;
          rsp_fault <= !pte_ok;
          rsp_paddr <= pte_ok ? {mem_rd_data[VPN_W-1:0], va_q[OFF_W-1:0]} : '0;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_v <= '0;
      rr    <= '0;
    end else begin
      if (flush)     ent_v     <= '0;
      else if (fill) ent_v[rr] <= 1'b1;
      if (fill) rr <= (rr == LAST) ? '0 : rr + 1'b1;
    end
  end

  always_ff @(posedge clk)
    if (fill) begin
      ent_tag[rr] <= vpn;
      ent_frm[rr] <= mem_rd_data[VPN_W-1:0];
    end
endmodule

module addr_xlate_chk #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [VA_W-1:0] req_vaddr,
  input logic            rsp_valid,
  input logic [VA_W-1:0] rsp_paddr,
  input logic            rsp_hit,
  input logic            rsp_fault,
  input logic            mem_rd_en,
  input logic [VA_W-1:0] mem_rd_addr,
  input logic            mem_rd_valid,
  input logic [VA_W-1:0] pt_base
);
  logic [VA_W-1:0] acc_va;
  always_ff @(posedge clk)
    if (!rst_n) acc_va <= '0;
    else if (req_valid && req_ready) acc_va <= req_vaddr;

  p_offset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_paddr[OFF_W-1:0] == acc_va[OFF_W-1:0]);
  p_hit_nomem_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_hit |-> !$past(mem_rd_en));
  p_rdaddr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> mem_rd_addr == pt_base + ({{OFF_W{1'b0}}, acc_va[VA_W-1:OFF_W]} << 2));
  p_rdhold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en && !mem_rd_valid |=> mem_rd_en);
  p_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_valid && !rsp_hit);
  p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready && !rsp_valid);
  p_idle_nomem_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_rd_en);
endmodule

bind addr_xlate addr_xlate_chk #(.VA_W(VA_W), .OFF_W(OFF_W)) u_chk (.*);

// File: tb/addr_xlate_bench.sv
`timescale 1ns/1ps
module addr_xlate_bench;
  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_ready;
  logic [31:0] req_vaddr = 0;
  logic        rsp_valid, rsp_hit, rsp_fault;
  logic [31:0] rsp_paddr;
  logic        mem_rd_en, mem_rd_valid = 0;
  logic [31:0] mem_rd_addr, mem_rd_data = 0;
  logic [31:0] pt_base = 32'h0004_0000;
  logic        flush = 0;

  addr_xlate u_addr_xlate (.*);

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc_all = 0;
  bit mv[8];
  logic [19:0] mt[8], mf[8];
  int mrr = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_all++;
    if (cyc_all > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got %0d expected %0d", cyc_all, 100000);
      finish_run();
    end
  end

  function automatic logic [31:0] pte_of(input logic [19:0] vpn);
    if (vpn[3:0] == 4'hF) return {1'b0, 11'h000, vpn ^ 20'h5A5A5};
    if (vpn[3:0] == 4'hE) return {1'b1, 11'h004, vpn ^ 20'h5A5A5};
    return {1'b1, 11'h000, vpn ^ 20'h5A5A5};
  endfunction

  task automatic do_flush();
    @(negedge clk) flush = 1;
    @(negedge clk) flush = 0;
    for (int i = 0; i < 8; i++) mv[i] = 0;
  endtask

  task automatic xlate(input logic [31:0] va, input bit flush_fill, input string req);
    logic [19:0] vpn = va[31:12];
    logic [31:0] pte = pte_of(vpn);
    bit exp_hit = 0, exp_fault, got = 0, saw_rd = 0, busy_bad = 0, addr_bad = 0;
    logic [19:0] exp_frm = 0;
    logic [31:0] exp_pa, bad_addr = 0, exp_addr;
    int cyc = 0, mcnt = 0, lat = vpn % 3;
    for (int i = 0; i < 8; i++) if (mv[i] && mt[i] == vpn) begin exp_hit = 1; exp_frm = mf[i]; end
    exp_fault = !exp_hit && !(pte[31] && pte[30:20] == 0);
    if (!exp_hit) exp_frm = pte[19:0];
    exp_pa = exp_fault ? 32'h0 : {exp_frm, va[11:0]};
    exp_addr = pt_base + {10'h0, vpn, 2'b00};
    @(negedge clk);
    check(req_ready === 1'b1, "R8", "ready before request", {31'h0, req_ready}, 1);
    req_valid = 1; req_vaddr = va;
    while (!got && cyc < 200) begin
      @(negedge clk);
      cyc++;
      req_valid = 0; mem_rd_valid = 0; flush = 0;
      if (rsp_valid) got = 1;
      else begin
        if (req_ready) busy_bad = 1;
        if (mem_rd_en) begin
          saw_rd = 1;
          if (mem_rd_addr !== exp_addr) begin addr_bad = 1; bad_addr = mem_rd_addr; end
          if (mcnt == lat) begin mem_rd_valid = 1; mem_rd_data = pte; flush = flush_fill; end
          mcnt++;
        end
      end
    end
    check(got, req, "response arrived", {31'h0, got}, 1);
    check(!busy_bad, "R8", "ready low while busy", {31'h0, busy_bad}, 0);
    check(rsp_hit === exp_hit, exp_hit ? "R2" : "R4", "hit flag", {31'h0, rsp_hit}, {31'h0, exp_hit});
    check(rsp_fault === exp_fault, exp_fault ? "R5" : "R4", "fault flag", {31'h0, rsp_fault}, {31'h0, exp_fault});
    check(rsp_paddr === exp_pa, req, "physical address", rsp_paddr, exp_pa);
    if (!exp_fault)
      check(rsp_paddr[11:0] === va[11:0], "R1", "offset", {20'h0, rsp_paddr[11:0]}, {20'h0, va[11:0]});
    check(req_ready === 1'b1, "R8", "ready with response", {31'h0, req_ready}, 1);
    if (exp_hit) begin
      check(cyc == 2, "R2", "hit latency", cyc, 2);
      check(!saw_rd, "R2", "no table read on hit", {31'h0, saw_rd}, 0);
    end else begin
      check(saw_rd, "R3", "table read on miss", {31'h0, saw_rd}, 1);
      check(!addr_bad, "R3", "entry address", bad_addr, exp_addr);
      check(cyc == lat + 3, "R3", "held until data", cyc, lat + 3);
    end
    if (flush_fill) for (int i = 0; i < 8; i++) mv[i] = 0;
    else if (!exp_hit && !exp_fault) begin
      mv[mrr] = 1; mt[mrr] = vpn; mf[mrr] = pte[19:0]; mrr = (mrr + 1) % 8;
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) mv[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(req_ready === 1 && rsp_valid === 0 && mem_rd_en === 0, "R9", "reset outputs",
          {29'h0, req_ready, rsp_valid, mem_rd_en}, 32'h4);
    xlate(32'h0001_2345, 0, "R9");
    xlate(32'h0001_2ABC, 0, "R2");
    xlate(32'h0003_0FFF, 0, "R4");
    xlate(32'h0003_0000, 0, "R1");
    xlate(32'h0000_F123, 0, "R5");
    xlate(32'h0000_F456, 0, "R5");
    xlate(32'h0001_E789, 0, "R5");
    xlate(32'h0001_E789, 0, "R5");
    do_flush();
    xlate(32'h0001_2345, 0, "R7");
    do_flush();
    for (int k = 0; k < 9; k++) xlate({20'h00100 + 20'(k), 12'h010 + 12'(k)}, 0, "R6");
    for (int k = 1; k < 9; k++) xlate({20'h00100 + 20'(k), 12'h7F0}, 0, "R6");
    xlate(32'h0010_0AAA, 0, "R6");
    xlate(32'h0020_5555, 1, "R7");
    xlate(32'h0020_5666, 0, "R7");
    xlate(32'h0020_5777, 0, "R4");
    pt_base = 32'hFFFF_F000;
    xlate(32'h0050_0321, 0, "R3");
    xlate(32'h0050_0123, 0, "R2");
    finish_run();
  end
endmodule